// File: doc/BRIEF.md
# Dual-Port Twiddle Factor Generator

This block supplies the rotation constants an FFT datapath multiplies by. Every clock it accepts two independent point indices and, two cycles later, returns one complex value for each index: the real part is cos(2πk/N) and the imaginary part is −sin(2πk/N), so each result is exp(−j·2πk/N). The point count N, the word width and the number of fractional bits are fixed at synthesis. N must be a power of two of at least 8, and the format must keep at least two integer bits, counting the sign.

Both results come from one shared sine table. The table holds only the first quarter wave, N/4+1 magnitudes, and each of its two read ports returns a mirrored pair of entries. The two top bits of each index pick a quadrant. The quadrant decides whether sine and cosine trade places and which of the two parts is negated. The table is computed during elaboration. Each entry is rounded to the nearest step of 2^−FRAC and clipped to the largest positive code. An input valid flag travels alongside the data through the two pipeline stages. The index ports are exactly log2(N) bits wide, so every index code is a legal point.

The pipeline has no control states. It always moves through two stages: a registered table read (stage A), then a registered sign and swap correction (stage B). A new index pair may enter on every cycle.

Top module: `twiddle_pair_gen`

## Requirements
- R1: For a valid index k, the real output is within ±1 LSB of round(cos(2πk/N)·2^FRAC), and the imaginary output is within ±1 LSB of round(−sin(2πk/N)·2^FRAC). Both are two's-complement signed words of WIDTH bits.
- R2: Ports 1 and 2 are independent. Any pair of indices presented in the same cycle produces both results in the same output cycle.
- R3: The data outputs and out_valid follow the inputs after exactly 2 clock cycles. out_valid is high exactly when in_valid was high two cycles earlier.
- R4: No output ever takes the most negative code −2^(WIDTH−1). Magnitudes are clipped to 2^(WIDTH−1)−1. With the default 16-bit, 14-fraction format, ±1 is represented exactly as ±16384.
- R5: The four cardinal indices are exact. With ONE = min(2^FRAC, 2^(WIDTH−1)−1), the outputs are: k=0 gives (ONE, 0); k=N/4 gives (0, −ONE); k=N/2 gives (−ONE, 0); k=3N/4 gives (0, +ONE).
- R6: While rst_n is low, out_valid and all four data outputs are zero.
- R7: Equal indices on both ports produce bit-identical results on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the index pair as valid |
| k1 | input | log2(N_POINTS) | Index for port 1 |
| k2 | input | log2(N_POINTS) | Index for port 2 |
| out_valid | output | 1 | in_valid delayed by two cycles |
| q1_re | output | WIDTH | Port 1 real part, cos |
| q1_im | output | WIDTH | Port 1 imaginary part, −sin |
| q2_re | output | WIDTH | Port 2 real part, cos |
| q2_im | output | WIDTH | Port 2 imaginary part, −sin |

## Verification
The assertions assume that in_valid, k1 and k2 carry known values on every clock edge outside reset. An unknown index would spread into the quadrant controls, and the exact-value properties would then not apply. The bench drives only defined values, changing them on the falling edge, and keeps in_valid low until reset has been released. Because the index ports are exactly log2(N) bits wide, every stimulus code is a legal index. The sweeps still pay deliberate attention to the quadrant seams, including the last code N−1.

// File: rtl/twg_pkg.sv
package twg_pkg;
    // Quadrant handling for one lookup: trade sine/cosine, negate either part
    typedef struct packed {
        logic swap;
        logic neg_re;
        logic neg_im;
    } fold_ctrl_t;
endpackage

// File: rtl/twg_fold.sv
module twg_fold
    import twg_pkg::*;
#(
    parameter int N_POINTS = 64,
    localparam int IW = $clog2(N_POINTS),
    localparam int AW = IW - 2
) (
    input  logic [IW-1:0] k,
    output logic [AW-1:0] addr,
    output fold_ctrl_t    ctrl
);
    logic [1:0] quad;
    assign quad = k[IW-1 -: 2];
    assign addr = k[AW-1:0];

    always_comb begin
        unique case (quad)
            2'd0: ctrl = '{swap: 1'b0, neg_re: 1'b0, neg_im: 1'b1};
            2'd1: ctrl = '{swap: 1'b1, neg_re: 1'b1, neg_im: 1'b1};
            2'd2: ctrl = '{swap: 1'b0, neg_re: 1'b1, neg_im: 1'b0};
            2'd3: ctrl = '{swap: 1'b1, neg_re: 1'b0, neg_im: 1'b0};
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/twg_quarter_rom.sv
module twg_quarter_rom #(
    parameter int N_POINTS = 64,
    parameter int WIDTH    = 16,
    parameter int FRAC     = 14,
    parameter int PORTS    = 2,
    localparam int QTR     = N_POINTS / 4,
    localparam int AW      = $clog2(N_POINTS) - 2,
    localparam int MAXPOS  = (1 << (WIDTH - 1)) - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS-1:0][AW-1:0]    addr,
    output logic [PORTS-1:0][WIDTH-1:0] mag_lo,
    output logic [PORTS-1:0][WIDTH-1:0] mag_hi
);
    localparam real PI = 3.14159265358979323846;

    logic [WIDTH-1:0] tab [QTR+1];

    // Quarter-wave sine magnitudes, rounded to nearest and clipped
    for (genvar i = 0; i <= QTR; i++) begin : g_tab
        localparam real SCALED = $sin(PI * real'(i) / (2.0 * real'(QTR)))
                                 * (2.0 ** FRAC) + 0.5;
        localparam int  RAW    = $rtoi(SCALED);
        localparam int  SAT    = (RAW > MAXPOS) ? MAXPOS : RAW;
        assign tab[i] = WIDTH'(SAT);
    end

    // Each port returns the entry at addr and its mirror at QTR-addr
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [AW:0] idx_hi;
        assign idx_hi = (AW+1)'(QTR) - {1'b0, addr[p]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mag_lo[p] <= '0;
                mag_hi[p] <= '0;
            end else begin
                mag_lo[p] <= tab[addr[p]];
                mag_hi[p] <= tab[idx_hi];
            end
        end

        // R4: a stored magnitude never exceeds the largest positive code
        p_mag_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mag_lo[p][WIDTH-1] == 1'b0) && (mag_hi[p][WIDTH-1] == 1'b0));
    end
endmodule

// File: rtl/twg_correct.sv
module twg_correct
    import twg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  fold_ctrl_t              ctrl,
    input  logic [WIDTH-1:0]        mag_lo,
    input  logic [WIDTH-1:0]        mag_hi,
    output logic signed [WIDTH-1:0] re,
    output logic signed [WIDTH-1:0] im
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic signed [WIDTH-1:0] sel_re, sel_im, nxt_re, nxt_im;

    always_comb begin
        sel_re = ctrl.swap ? signed'(mag_lo) : signed'(mag_hi);
        sel_im = ctrl.swap ? signed'(mag_hi) : signed'(mag_lo);
        nxt_re = ctrl.neg_re ? -sel_re : sel_re;
        nxt_im = ctrl.neg_im ? -sel_im : sel_im;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            re <= '0;
            im <= '0;
        end else begin
            re <= nxt_re;
            im <= nxt_im;
        end
    end

    // R4: the asymmetric negative code never appears
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (re != MOST_NEG) && (im != MOST_NEG));
endmodule

// File: rtl/twiddle_pair_gen.sv
module twiddle_pair_gen
    import twg_pkg::*;
#(
    parameter int N_POINTS = 64,
    parameter int WIDTH    = 16,
    parameter int FRAC     = 14,
    localparam int IW      = $clog2(N_POINTS),
    localparam int AW      = IW - 2,
    localparam int PORTS   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IW-1:0]           k1,
    input  logic [IW-1:0]           k2,
    output logic                    out_valid,
    output logic signed [WIDTH-1:0] q1_re,
    output logic signed [WIDTH-1:0] q1_im,
    output logic signed [WIDTH-1:0] q2_re,
    output logic signed [WIDTH-1:0] q2_im
);
    localparam int MAXPOS  = (1 << (WIDTH - 1)) - 1;
    localparam int ONE_INT = ((1 << FRAC) > MAXPOS) ? MAXPOS : (1 << FRAC);
    localparam logic signed [WIDTH-1:0] ONE      = WIDTH'(ONE_INT);
    localparam logic signed [WIDTH-1:0] NEG_ONE  = -ONE;
    localparam logic [IW-1:0]           IDX_Q1   = IW'(N_POINTS / 4);
    localparam logic [IW-1:0]           IDX_HALF = IW'(N_POINTS / 2);

    logic [PORTS-1:0][IW-1:0]    idx;
    logic [PORTS-1:0][AW-1:0]    addr;
    logic [PORTS-1:0][WIDTH-1:0] mag_lo, mag_hi;
    logic [PORTS-1:0][WIDTH-1:0] res_re, res_im;
    fold_ctrl_t                  ctrl_c [PORTS];
    fold_ctrl_t                  ctrl_a [PORTS];
    logic                        vld_a, vld_b;

    assign idx[0] = k1;
    assign idx[1] = k2;

    for (genvar p = 0; p < PORTS; p++) begin : g_lane
        twg_fold #(.N_POINTS(N_POINTS)) u_fold (
            .k    (idx[p]),
            .addr (addr[p]),
            .ctrl (ctrl_c[p])
        );

        // Stage A: quadrant controls ride alongside the table read
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctrl_a[p] <= '0;
            else        ctrl_a[p] <= ctrl_c[p];
        end

        // Stage B: sign and swap correction
        twg_correct #(.WIDTH(WIDTH)) u_correct (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl   (ctrl_a[p]),
            .mag_lo (mag_lo[p]),
            .mag_hi (mag_hi[p]),
            .re     (res_re[p]),
            .im     (res_im[p])
        );
    end

    twg_quarter_rom #(
        .N_POINTS (N_POINTS),
        .WIDTH    (WIDTH),
        .FRAC     (FRAC),
        .PORTS    (PORTS)
    ) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .mag_lo (mag_lo),
        .mag_hi (mag_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_a <= 1'b0;
            vld_b <= 1'b0;
        end else begin
            vld_a <= in_valid;
            vld_b <= vld_a;
        end
    end

    assign out_valid = vld_b;
    assign q1_re     = res_re[0];
    assign q1_im     = res_im[0];
    assign q2_re     = res_re[1];
    assign q2_im     = res_im[1];

    // R3: valid appears two cycles after it enters, and only then
    p_valid_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    p_idle_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R5: cardinal points are exact on port 1
    p_zero_pt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k1 == '0) |-> ##2 (q1_re == ONE && q1_im == '0));
    p_quarter_pt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k1 == IDX_Q1) |-> ##2 (q1_re == '0 && q1_im == NEG_ONE));
    p_half_pt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k1 == IDX_HALF) |-> ##2 (q1_re == NEG_ONE && q1_im == '0));

    // R7: equal indices give identical results on both ports
    p_same_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (k1 == k2) |-> ##2 (q1_re == q2_re && q1_im == q2_im));

    // R6: outputs held at zero in reset
    always_comb begin
        if (!rst_n) begin
            a_reset_clear_r6: assert (out_valid == 1'b0 && q1_re == '0 && q1_im == '0
                                      && q2_re == '0 && q2_im == '0);
        end
    end
endmodule

// File: tb/test_twiddle_pair_gen.sv
module test_twiddle_pair_gen;
    localparam int N     = 64;
    localparam int W     = 16;
    localparam int F     = 14;
    localparam int IW    = $clog2(N);
    localparam int MAXP  = (1 << (W - 1)) - 1;
    localparam int ONE   = ((1 << F) > MAXP) ? MAXP : (1 << F);
    localparam real PI   = 3.14159265358979323846;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [IW-1:0]       k1 = '0, k2 = '0;
    logic                out_valid;
    logic signed [W-1:0] q1_re, q1_im, q2_re, q2_im;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct { bit v; int a; int b; } req_t;
    req_t pending[$];

    always #10 clk = ~clk;

    twiddle_pair_gen #(.N_POINTS(N), .WIDTH(W), .FRAC(F)) i_twiddle_pair_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .k1(k1), .k2(k2),
        .out_valid(out_valid), .q1_re(q1_re), .q1_im(q1_im),
        .q2_re(q2_re), .q2_im(q2_im)
    );

    function automatic int quant(real x);
        int r;
        r = $rtoi($floor(x * (2.0 ** F) + 0.5));
        if (r > MAXP)  r = MAXP;
        if (r < -MAXP) r = -MAXP;
        return r;
    endfunction

    function automatic int exp_re(int k);
        return quant($cos(2.0 * PI * real'(k) / real'(N)));
    endfunction

    function automatic int exp_im(int k);
        return quant(-$sin(2.0 * PI * real'(k) / real'(N)));
    endfunction

    task automatic check_near(string tag, int act, int exp_v);
        int d;
        d = act - exp_v;
        checks++;
        if (d > 1 || d < -1) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic check_eq(string tag, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Called on a falling edge: compare, then queue and drive the next pair
    task automatic step(bit v, int a, int b);
        req_t r;
        if (pending.size() == 2) begin
            r = pending.pop_front();
            check_eq("R3 out_valid", int'(out_valid), int'(r.v));
            if (r.v) begin
                check_near("R1 R2 port1 re", int'(q1_re), exp_re(r.a));
                check_near("R1 R2 port1 im", int'(q1_im), exp_im(r.a));
                check_near("R1 R2 port2 re", int'(q2_re), exp_re(r.b));
                check_near("R1 R2 port2 im", int'(q2_im), exp_im(r.b));
                check_eq("R4 no most-negative code",
                         int'(q1_re == -(MAXP + 1) || q1_im == -(MAXP + 1) ||
                              q2_re == -(MAXP + 1) || q2_im == -(MAXP + 1)), 0);
                if (r.a == r.b) begin
                    check_eq("R7 equal re", int'(q1_re), int'(q2_re));
                    check_eq("R7 equal im", int'(q1_im), int'(q2_im));
                end
                if (r.a % (N / 4) == 0) begin
                    case (r.a / (N / 4))
                        0: begin check_eq("R5 k=0 re", int'(q1_re), ONE);
                                 check_eq("R5 k=0 im", int'(q1_im), 0); end
                        1: begin check_eq("R5 k=N/4 re", int'(q1_re), 0);
                                 check_eq("R5 k=N/4 im", int'(q1_im), -ONE); end
                        2: begin check_eq("R5 k=N/2 re", int'(q1_re), -ONE);
                                 check_eq("R5 k=N/2 im", int'(q1_im), 0); end
                        default: begin check_eq("R5 k=3N/4 re", int'(q1_re), 0);
                                 check_eq("R5 k=3N/4 im", int'(q1_im), ONE); end
                    endcase
                end
            end
        end
        r.v = v; r.a = a; r.b = b;
        pending.push_back(r);
        in_valid = v;
        k1 = IW'(a);
        k2 = IW'(b);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check_eq("R6 reset out_valid", int'(out_valid), 0);
        check_eq("R6 reset q1_re", int'(q1_re), 0);
        check_eq("R6 reset q1_im", int'(q1_im), 0);
        check_eq("R6 reset q2_re", int'(q2_re), 0);
        check_eq("R6 reset q2_im", int'(q2_im), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R5: full sweep, port 2 running backwards
        for (int i = 0; i < N; i++) step(1'b1, i, N - 1 - i);
        // R7: identical indices
        for (int i = 0; i < N; i++) step(1'b1, i, i);
        // R3: valid gaps and random pairs
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)),
                 int'($urandom_range(0, N - 1)));
        // Quadrant seams
        for (int q = 0; q < 4; q++) begin
            step(1'b1, q * N / 4, (q * N / 4 + N - 1) % N);
            step(1'b1, (q * N / 4 + 1) % N, q * N / 4);
        end
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule